// File: doc/BRIEF.md
# Unaligned-Start Read Burst Beat Generator

This block answers AXI4 incrementing read bursts from a small on-block byte memory and handles start addresses that are not aligned to the data bus. After the read address channel hands over a start address, a beat count and a beat size, the block returns one data beat at a time. Each byte it fetches goes on the lane equal to its address modulo the bus byte count. Only the first beat may begin part-way into a bus word. Every later beat begins at a base aligned to the beat size, so the lanes below the start address in the first beat are never read from memory.

Lanes that carry no requested byte are driven with a filler byte when the fill parameter is set. The memory is a register array that loads a fixed address-derived pattern at reset and has a one-cycle read port with a per-lane enable. A three-state controller sequences each beat. In IDLE it takes a request (transition AR_ACCEPT) into FETCH. FETCH issues the memory read and moves on (DATA_READY) to SEND. SEND holds the beat until it is taken, then goes back to FETCH (NEXT_BEAT), or returns to IDLE after the final beat (BURST_DONE).

Top module: `axi_rd_beat_gen`

## Requirements
- R1: After reset, arready is 1 and rvalid is 0.
- R2: A byte at address a is placed on lane a mod 4 (32-bit bus). The memory byte at address a is (7*a + 3) mod 256.
- R3: In the first beat, lanes below the start address are driven with the filler byte 0xEE and are not read. This also applies to lanes above the beat-size window that contains the start address.
- R4: Beat n>0 covers the 2^arsize bytes starting at (start rounded down to 2^arsize) + n*2^arsize. In a two-beat 4-byte burst from address 1, lane 0 of the second beat holds byte 4, not byte 8.
- R5: With arsize below the bus width, only the lanes of the current beat window carry data. All other lanes carry 0xEE.
- R6: rlast is 1 on beat number arlen (counting from 0) and 0 on every earlier beat. rresp is 2'b00 on every beat.
- R7: A beat completes only on a cycle with rvalid and rready both 1. While rvalid is 1 and rready is 0, rdata and rlast stay unchanged.
- R8: arready is 0 from the accepting edge until the final beat is transferred. An arvalid presented in that interval is not taken.
- R9: rvalid rises in the second cycle after the address handshake edge, and again in the second cycle after each non-final beat handshake.
- R10: Byte addresses wrap modulo the memory size of 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Read request accepted when high with arvalid |
| araddr | input | 16 | Byte start address |
| arlen | input | 8 | Beats in the burst minus one |
| arsize | input | 3 | Log2 of bytes per beat, at most 2 |
| rvalid | output | 1 | Read beat valid |
| rready | input | 1 | Read beat accepted when high with rvalid |
| rdata | output | 32 | Read beat data, lane i is bits 8i+7..8i |
| rresp | output | 2 | Response code, always OKAY |
| rlast | output | 1 | Final beat of the burst |

## Verification
Every result has a fixed cycle offset. rvalid is due two clock edges after the address handshake and two edges after each beat handshake, and the data and rlast arrive in that same cycle. While rvalid waits for rready, the beat must not change. The bench drives inputs on falling edges and counts falling edges from each handshake. It checks that rvalid is low at the first one and high, with the expected lanes, at the second. During stalls it compares every stalled cycle against the first copy of the beat.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } rbg_state_t;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/rbg_mem.sv
module rbg_mem #(
    parameter int DATA_W    = 32,
    parameter int WORDS     = 64,
    parameter int PAT_MUL   = 7,
    parameter int PAT_ADD   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [$clog2(WORDS)-1:0]      rd_word,
    input  logic [DATA_W/8-1:0]           rd_lane_en,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int NB = DATA_W / 8;

    logic [7:0] store_q [WORDS][NB];
    logic [7:0] out_q   [NB];

    function automatic logic [7:0] pattern(input int addr);
        int v;
        v = addr * PAT_MUL + PAT_ADD;
        return v[7:0];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                for (int l = 0; l < NB; l++) begin
                    store_q[w][l] <= pattern(w * NB + l);
                end
            end
        end
    end

    generate
        for (genvar l = 0; l < NB; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_q[l] <= '0;
                end else if (rd_en && rd_lane_en[l]) begin
                    out_q[l] <= store_q[rd_word][l];
                end
            end
            assign rd_data[8*l +: 8] = out_q[l];
        end
    endgenerate

    // a_r3_lane_untouched: a lane not enabled keeps its register
    a_r3_lane_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_lane_en[0]) |=> $stable(rd_data[7:0]));
endmodule

// File: rtl/rbg_addr.sv
module rbg_addr #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 64,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0]          start_addr,
    input  logic [2:0]                 size,
    input  logic [LEN_W-1:0]           beat_idx,
    output logic [$clog2(WORDS)-1:0]   word_idx,
    output logic [DATA_W/8-1:0]        lane_mask
);
    localparam int NB = DATA_W / 8;
    localparam int LB = $clog2(NB);
    localparam int IW = $clog2(WORDS);

    logic [ADDR_W-1:0] span_m1;
    logic [ADDR_W-1:0] base_aligned;
    logic [ADDR_W-1:0] window_base;
    logic [ADDR_W-1:0] beat_addr;
    logic [LB:0]       first_lane;
    logic [LB:0]       last_lane;

    always_comb begin
        span_m1      = (ADDR_W'(1) << size) - ADDR_W'(1);
        base_aligned = start_addr & ~span_m1;
        window_base  = base_aligned + (ADDR_W'(beat_idx) << size);
        beat_addr    = (beat_idx == '0) ? start_addr : window_base;
        first_lane   = {1'b0, beat_addr[LB-1:0]};
        last_lane    = {1'b0, window_base[LB-1:0]} + span_m1[LB:0];
        word_idx     = beat_addr[LB +: IW];
    end

    generate
        for (genvar l = 0; l < NB; l++) begin : g_mask
            assign lane_mask[l] = ((LB+1)'(l) >= first_lane) && ((LB+1)'(l) <= last_lane);
        end
    endgenerate
endmodule

// File: rtl/rbg_ctrl.sv
module rbg_ctrl
    import rbg_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 8,
    parameter int MAX_SIZE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arvalid,
    output logic               arready,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic [LEN_W-1:0]   arlen,
    input  logic [2:0]         arsize,
    input  logic               rready,
    output logic               rvalid,
    output logic               rlast,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  start_q,
    output logic [2:0]         size_q,
    output logic [LEN_W-1:0]   beat_q
);
    rbg_state_t       state_q, state_d;
    logic [LEN_W-1:0] len_q;
    logic             ar_hs;
    logic             r_hs;

    assign ar_hs = arvalid && arready;
    assign r_hs  = rvalid && rready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arvalid) state_d = ST_FETCH;           // AR_ACCEPT
            ST_FETCH: state_d = ST_SEND;                        // DATA_READY
            ST_SEND:  if (rready) state_d = (beat_q == len_q) ? ST_IDLE   // BURST_DONE
                                                              : ST_FETCH; // NEXT_BEAT
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            size_q  <= '0;
            len_q   <= '0;
            beat_q  <= '0;
        end else if (ar_hs) begin
            start_q <= araddr;
            size_q  <= arsize;
            len_q   <= arlen;
            beat_q  <= '0;
        end else if (r_hs && (beat_q != len_q)) begin
            beat_q  <= beat_q + LEN_W'(1);
        end
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        rd_en   = 1'b0;
        rlast   = 1'b0;
        unique case (state_q)
            ST_IDLE:  arready = 1'b1;
            ST_FETCH: rd_en   = 1'b1;
            ST_SEND: begin
                rvalid = 1'b1;
                rlast  = (beat_q == len_q);
            end
            default: ;
        endcase
    end

    // R8: no request taken while a burst is in flight
    a_r8_busy_blocks_ar: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !arready);
    // R7: beat held while the receiver stalls
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rlast) && $stable(beat_q)));
    // R9: a fetch is always followed by a valid beat
    a_r9_fetch_to_send: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> rvalid);
    // R4: beat size never wider than the bus
    a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ar_hs |-> (arsize <= 3'(MAX_SIZE)));
endmodule

// File: rtl/axi_rd_beat_gen.sv
module axi_rd_beat_gen
    import rbg_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         DATA_W    = 32,
    parameter int         LEN_W     = 8,
    parameter int         MEM_WORDS = 64,
    parameter bit         FILL_EN   = 1'b1,
    parameter logic [7:0] FILL_BYTE = 8'hEE,
    parameter int         PAT_MUL   = 7,
    parameter int         PAT_ADD   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arvalid,
    output logic               arready,
    input  logic [ADDR_W-1:0]  araddr,
    input  logic [LEN_W-1:0]   arlen,
    input  logic [2:0]         arsize,
    output logic               rvalid,
    input  logic               rready,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rresp,
    output logic               rlast
);
    localparam int NB       = DATA_W / 8;
    localparam int MAX_SIZE = $clog2(NB);
    localparam int IW       = $clog2(MEM_WORDS);

    logic              rd_en;
    logic [ADDR_W-1:0] start_q;
    logic [2:0]        size_q;
    logic [LEN_W-1:0]  beat_q;
    logic [IW-1:0]     word_idx;
    logic [NB-1:0]     lane_mask;
    logic [NB-1:0]     lane_q;
    logic [DATA_W-1:0] mem_data;

    rbg_ctrl #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .MAX_SIZE (MAX_SIZE)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arvalid (arvalid),
        .arready (arready),
        .araddr  (araddr),
        .arlen   (arlen),
        .arsize  (arsize),
        .rready  (rready),
        .rvalid  (rvalid),
        .rlast   (rlast),
        .rd_en   (rd_en),
        .start_q (start_q),
        .size_q  (size_q),
        .beat_q  (beat_q)
    );

    rbg_addr #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (MEM_WORDS),
        .LEN_W  (LEN_W)
    ) u_addr (
        .start_addr (start_q),
        .size       (size_q),
        .beat_idx   (beat_q),
        .word_idx   (word_idx),
        .lane_mask  (lane_mask)
    );

    rbg_mem #(
        .DATA_W  (DATA_W),
        .WORDS   (MEM_WORDS),
        .PAT_MUL (PAT_MUL),
        .PAT_ADD (PAT_ADD)
    ) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_word    (word_idx),
        .rd_lane_en (lane_mask),
        .rd_data    (mem_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)     lane_q <= '0;
        else if (rd_en) lane_q <= lane_mask;
    end

    generate
        for (genvar l = 0; l < NB; l++) begin : g_out
            if (FILL_EN) begin : g_fill
                assign rdata[8*l +: 8] = lane_q[l] ? mem_data[8*l +: 8] : FILL_BYTE;
            end else begin : g_raw
                assign rdata[8*l +: 8] = mem_data[8*l +: 8];
            end
        end
    endgenerate

    assign rresp = RESP_OKAY;

    // R7: data frozen while the beat waits
    a_r7_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> $stable(rdata));
    // R6: after the final beat the address channel reopens
    a_r6_last_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && rlast) |=> (arready && !rvalid));
    // R5: every fetched beat carries at least one lane
    a_r5_lane_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (lane_mask != '0));
    // R8: request and data phases never overlap
    a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(arready && rvalid));
endmodule

// File: tb/axi_rd_beat_gen_tb.sv
module axi_rd_beat_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [15:0] araddr = '0;
    logic [7:0]  arlen = '0;
    logic [2:0]  arsize = '0;
    logic        rvalid;
    logic        rready = 1'b0;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rlast;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    axi_rd_beat_gen u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .arvalid (arvalid),
        .arready (arready),
        .araddr  (araddr),
        .arlen   (arlen),
        .arsize  (arsize),
        .rvalid  (rvalid),
        .rready  (rready),
        .rdata   (rdata),
        .rresp   (rresp),
        .rlast   (rlast)
    );

    localparam int NV = 8;
    //                          R4  R2  R5  R3  R5  R3  R10 R4
    localparam int V_ADDR [NV] = '{1,  0,  6,  7, 13,  3, 250, 2};
    localparam int V_LEN  [NV] = '{1,  3,  2,  1,  4,  0,   2, 2};
    localparam int V_SIZE [NV] = '{2,  2,  1,  1,  0,  2,   2, 2};
    localparam int V_STALL[NV] = '{0,  2,  1,  0,  3,  0,   1, 0};
    localparam int V_BUSY [NV] = '{0,  1,  0,  0,  0,  0,   0, 1};

    function automatic logic [7:0] mem_byte(input int a);
        int v;
        v = (a % 256) * 7 + 3;
        return v[7:0];
    endfunction

    function automatic logic [31:0] expect_beat(input int addr, input int size, input int n);
        logic [31:0] e;
        int bytes, base, lo, hi;
        bytes = 1 << size;
        base  = (addr / bytes) * bytes;
        lo    = (n == 0) ? addr : base + n * bytes;
        hi    = base + (n + 1) * bytes - 1;
        e     = {4{8'hEE}};
        for (int b = lo; b <= hi; b++) e[8*(b%4) +: 8] = mem_byte(b);
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_burst(input int addr, input int len, input int size,
                            input int stall, input int busy);
        logic [31:0] held;
        @(negedge clk);
        araddr = 16'(addr); arlen = 8'(len); arsize = 3'(size); arvalid = 1'b1;
        check("R8 arready idle", 32'(arready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        if (busy != 0) araddr = 16'h0040; else arvalid = 1'b0;
        for (int n = 0; n <= len; n++) begin
            check("R9 gap before beat", 32'(rvalid), 32'd0);
            if (busy != 0) check("R8 arready busy", 32'(arready), 32'd0);
            @(negedge clk);
            check("R9 rvalid due", 32'(rvalid), 32'd1);
            check("R2 R3 R4 R5 rdata", rdata, expect_beat(addr, size, n));
            check("R6 rlast", 32'(rlast), (n == len) ? 32'd1 : 32'd0);
            check("R6 rresp", 32'(rresp), 32'd0);
            held = rdata;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check("R7 stall rvalid", 32'(rvalid), 32'd1);
                check("R7 stall rdata", rdata, held);
                if (busy != 0) check("R8 arready busy", 32'(arready), 32'd0);
            end
            if (n == len) arvalid = 1'b0;
            rready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rready = 1'b0;
        end
        check("R8 arready after last", 32'(arready), 32'd1);
        check("R6 no beat after last", 32'(rvalid), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 arready reset", 32'(arready), 32'd1);
        check("R1 rvalid reset", 32'(rvalid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 arready after reset", 32'(arready), 32'd1);
        check("R1 rvalid after reset", 32'(rvalid), 32'd0);

        for (int v = 0; v < NV; v++)
            do_burst(V_ADDR[v], V_LEN[v], V_SIZE[v], V_STALL[v], V_BUSY[v]);

        // R4 directed: second beat lane 0 is byte 4, not byte 8
        @(negedge clk);
        araddr = 16'd1; arlen = 8'd1; arsize = 3'd2; arvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        @(negedge clk);
        check("R3 first beat lane0 filler", 32'(rdata[7:0]), 32'hEE);
        check("R2 first beat lane1 byte1", 32'(rdata[15:8]), 32'(mem_byte(1)));
        // R7: hold rready low, beat must not advance
        repeat (4) @(negedge clk);
        check("R7 no advance without rready", 32'(rlast), 32'd0);
        rready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rready = 1'b0;
        @(negedge clk);
        check("R4 second beat lane0 byte4", 32'(rdata[7:0]), 32'(mem_byte(4)));
        check("R4 second beat full", rdata, {mem_byte(7), mem_byte(6), mem_byte(5), mem_byte(4)});
        check("R6 second beat last", 32'(rlast), 32'd1);
        rready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rready = 1'b0;

        // R10 directed: single byte at the top of memory, then wrap
        do_burst(255, 1, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule